// File: doc/BRIEF.md
# CRTC Raster Timing Generator

This block produces the raster timing of one display head: a horizontal position counted in character cells of eight pixels, a scanline counter, horizontal and vertical blanking, the two sync pulses, a display-enable and a vertical-retrace flag. It advances only on cycles where the pixel enable is high. It is configured through a small write port that holds the timing values in the compact coded form used by classic VGA display controllers. Totals and display ends are stored with fixed offsets. The ends of blanking and sync are kept as a few low bits that are matched against the running counter.

Every write lands in a pending register set. The whole set is copied into the active set on the pixel that wraps the last line of a frame. This means a frame is always drawn with a single consistent mode, however the writes are spread in time. Polarity and disable bits let the sync outputs be inverted or held idle. A screen-off bit blanks the picture while the counters keep running.

Top module: `crtc_timing_gen`

## Requirements
- R1: After reset the counters are at character 0 of line 0 and both register sets hold the default mode: total 5, display end 5, blank start 5, blank end 9, sync start 7, sync end 8 (horizontal), total 6, display end 5, blank start 5, blank end 7, sync start 6, sync end 7 (vertical), polarity 0, control 0.
- R2: A line is (horizontal total + 5) characters of 2**DOT_W pixels. Characters 0 through the horizontal display-end value are in the horizontal display region.
- R3: A frame is (vertical total + 2) lines. Lines 0 through the vertical display-end value are in the vertical display region. line_o gives the current line and only holds, steps by one, or wraps to 0.
- R4: de_o is high exactly when the character and the line are both inside their display regions and the screen is on.
- R5: Horizontal blanking starts at character (blank start + 1). It ends at the first later character whose low 6 bits equal the low 6 bits of the blank-end value. blank_o is the OR of horizontal blanking, vertical blanking and screen-off.
- R6: Vertical blanking starts at line (blank start + 1). It ends at the first later line whose low 8 bits equal the low 8 bits of the blank-end value.
- R7: The horizontal sync pulse starts at character (sync start) and lasts ((sync end − sync start) mod 32) characters. A result of 0 gives 32.
- R8: The vertical sync pulse starts at line (sync start) and lasts ((sync end − sync start) mod 16) lines. A result of 0 gives 16. vretrace_o is high during this pulse, whatever the polarity and disable settings.
- R9: Polarity register (address 12): bit 6 set makes hsync_o active low, and bit 7 set makes vsync_o active low.
- R10: Control register (address 13): bit 7 holds hsync_o at its inactive level, and bit 6 does the same for vsync_o. Bit 5 turns the screen off, which forces de_o low and blank_o high while the counters run on.
- R11: The write addresses are 0–5 for the horizontal total, display end, blank start, blank end, sync start and sync end, and 6–11 for the same six vertical values. A write changes nothing on the outputs until the first pixel of the next frame.
- R12: While pix_en_i is low, no counter, flag or output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Advances the raster by one pixel |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address (0–13) |
| wr_data_i | input | 12 | Coded register value |
| hsync_o | output | 1 | Horizontal sync after polarity and disable |
| vsync_o | output | 1 | Vertical sync after polarity and disable |
| de_o | output | 1 | Display enable |
| blank_o | output | 1 | Composite blanking |
| line_o | output | 11 | Current scanline |
| vretrace_o | output | 1 | Vertical retrace in progress |

## Verification
The bench drives a horizontal sync whose coded end matches the start in all five compared bits. A design that compares too many bits, or that lets the end win over the start, would give a pulse of 0 or 1 character instead of 32. The same test is run on the vertical sync with 4 bits, where the expected width is 16 lines. Blank-end values carry bits above the compared field, so a full-width compare would leave blanking on until the frame wraps. Writes are issued in the middle of frames, so a design that applies them at once would tear that frame. A pixel-enable stall pattern catches any counter that moves on a disabled cycle.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  parameter int unsigned HC_W   = 9;
  parameter int unsigned VC_W   = 11;
  parameter int unsigned ADDR_W = 4;

  typedef struct packed {
    logic [HC_W-1:0] htot;
    logic [HC_W-1:0] hde;
    logic [HC_W-1:0] hbs;
    logic [HC_W-1:0] hbe;
    logic [HC_W-1:0] hss;
    logic [HC_W-1:0] hse;
    logic [VC_W-1:0] vtot;
    logic [VC_W-1:0] vde;
    logic [VC_W-1:0] vbs;
    logic [VC_W-1:0] vbe;
    logic [VC_W-1:0] vss;
    logic [VC_W-1:0] vse;
    logic            hneg;
    logic            vneg;
    logic            hdis;
    logic            vdis;
    logic            scr_off;
  } crtc_cfg_t;

  localparam crtc_cfg_t CFG_RST = '{
    htot: HC_W'(5), hde: HC_W'(5), hbs: HC_W'(5), hbe: HC_W'(9),
    hss: HC_W'(7), hse: HC_W'(8),
    vtot: VC_W'(6), vde: VC_W'(5), vbs: VC_W'(5), vbe: VC_W'(7),
    vss: VC_W'(6), vse: VC_W'(7),
    hneg: 1'b0, vneg: 1'b0, hdis: 1'b0, vdis: 1'b0, scr_off: 1'b0
  };
endpackage

// File: rtl/crtc_shadow_regs.sv
module crtc_shadow_regs
  import crtc_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_i,
  output crtc_cfg_t         act_o,
  output crtc_cfg_t         nxt_o
);
  crtc_cfg_t pend_q, pend_d, act_q;

  always_comb begin
    pend_d = pend_q;
    if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_W'(0):  pend_d.htot = wr_data_i[HC_W-1:0];
        ADDR_W'(1):  pend_d.hde  = wr_data_i[HC_W-1:0];
        ADDR_W'(2):  pend_d.hbs  = wr_data_i[HC_W-1:0];
        ADDR_W'(3):  pend_d.hbe  = wr_data_i[HC_W-1:0];
        ADDR_W'(4):  pend_d.hss  = wr_data_i[HC_W-1:0];
        ADDR_W'(5):  pend_d.hse  = wr_data_i[HC_W-1:0];
        ADDR_W'(6):  pend_d.vtot = wr_data_i[VC_W-1:0];
        ADDR_W'(7):  pend_d.vde  = wr_data_i[VC_W-1:0];
        ADDR_W'(8):  pend_d.vbs  = wr_data_i[VC_W-1:0];
        ADDR_W'(9):  pend_d.vbe  = wr_data_i[VC_W-1:0];
        ADDR_W'(10): pend_d.vss  = wr_data_i[VC_W-1:0];
        ADDR_W'(11): pend_d.vse  = wr_data_i[VC_W-1:0];
        ADDR_W'(12): begin
          pend_d.hneg = wr_data_i[6];
          pend_d.vneg = wr_data_i[7];
        end
        ADDR_W'(13): begin
          pend_d.hdis    = wr_data_i[7];
          pend_d.vdis    = wr_data_i[6];
          pend_d.scr_off = wr_data_i[5];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= CFG_RST;
      act_q  <= CFG_RST;
    end else begin
      pend_q <= pend_d;
      if (load_i) act_q <= pend_q;
    end
  end

  assign act_o = act_q;
  // settings seen by the flag logic on the pixel that enters the next frame
  assign nxt_o = load_i ? pend_q : act_q;
endmodule

// File: rtl/crtc_hgen.sv
module crtc_hgen
  import crtc_pkg::*;
#(
  parameter int unsigned DOT_W = 3,
  parameter int unsigned BE_W  = 6,
  parameter int unsigned SE_W  = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pix_en_i,
  input  crtc_cfg_t       cur_i,
  input  crtc_cfg_t       nxt_i,
  output logic [HC_W-1:0] char_o,
  output logic            line_end_o,
  output logic            blank_o,
  output logic            sync_o
);
  localparam logic [DOT_W-1:0] DOT_LAST = '1;
  localparam logic [HC_W:0]    TOT_OFS  = (HC_W+1)'(4);
  localparam logic [HC_W:0]    ONE_X    = (HC_W+1)'(1);

  logic [DOT_W-1:0] dot_q;
  logic [HC_W-1:0]  char_q, char_n;
  logic             blank_q, sync_q;
  logic             char_step, at_last;
  logic             blank_set, blank_clr, sync_set, sync_clr;

  assign char_step = pix_en_i && (dot_q == DOT_LAST);
  assign at_last   = ({1'b0, char_q} == ({1'b0, cur_i.htot} + TOT_OFS));
  assign char_n    = at_last ? '0 : char_q + HC_W'(1);

  assign blank_set = ({1'b0, char_n} == ({1'b0, nxt_i.hbs} + ONE_X));
  assign blank_clr = (char_n[BE_W-1:0] == nxt_i.hbe[BE_W-1:0]);
  assign sync_set  = (char_n == nxt_i.hss);
  assign sync_clr  = (char_n[SE_W-1:0] == nxt_i.hse[SE_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dot_q   <= '0;
      char_q  <= '0;
      blank_q <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      if (pix_en_i) dot_q <= dot_q + DOT_W'(1);
      if (char_step) begin
        char_q <= char_n;
        // start wins over a matching end, giving the full wrap width
        if (blank_set)      blank_q <= 1'b1;
        else if (blank_clr) blank_q <= 1'b0;
        if (sync_set)       sync_q  <= 1'b1;
        else if (sync_clr)  sync_q  <= 1'b0;
      end
    end
  end

  assign char_o     = char_q;
  assign line_end_o = char_step && at_last;
  assign blank_o    = blank_q;
  assign sync_o     = sync_q;
endmodule

// File: rtl/crtc_vgen.sv
module crtc_vgen
  import crtc_pkg::*;
#(
  parameter int unsigned BE_W = 8,
  parameter int unsigned SE_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            line_adv_i,
  input  crtc_cfg_t       cur_i,
  input  crtc_cfg_t       nxt_i,
  output logic [VC_W-1:0] line_o,
  output logic            frame_end_o,
  output logic            blank_o,
  output logic            sync_o
);
  localparam logic [VC_W:0] ONE_X = (VC_W+1)'(1);

  logic [VC_W-1:0] line_q, line_n;
  logic            blank_q, sync_q;
  logic            at_last, blank_set, blank_clr, sync_set, sync_clr;

  assign at_last   = ({1'b0, line_q} == ({1'b0, cur_i.vtot} + ONE_X));
  assign line_n    = at_last ? '0 : line_q + VC_W'(1);

  assign blank_set = ({1'b0, line_n} == ({1'b0, nxt_i.vbs} + ONE_X));
  assign blank_clr = (line_n[BE_W-1:0] == nxt_i.vbe[BE_W-1:0]);
  assign sync_set  = (line_n == nxt_i.vss);
  assign sync_clr  = (line_n[SE_W-1:0] == nxt_i.vse[SE_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      blank_q <= 1'b0;
      sync_q  <= 1'b0;
    end else if (line_adv_i) begin
      line_q <= line_n;
      if (blank_set)      blank_q <= 1'b1;
      else if (blank_clr) blank_q <= 1'b0;
      if (sync_set)       sync_q  <= 1'b1;
      else if (sync_clr)  sync_q  <= 1'b0;
    end
  end

  assign line_o      = line_q;
  assign frame_end_o = line_adv_i && at_last;
  assign blank_o     = blank_q;
  assign sync_o      = sync_q;
endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
  import crtc_pkg::*;
#(
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned DOT_W     = 3,
  parameter int unsigned HBE_CMP_W = 6,
  parameter int unsigned HSE_CMP_W = 5,
  parameter int unsigned VBE_CMP_W = 8,
  parameter int unsigned VSE_CMP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              blank_o,
  output logic [VC_W-1:0]   line_o,
  output logic              vretrace_o
);
  crtc_cfg_t       cfg_act, cfg_nxt;
  logic            line_end, frame_end;
  logic            hblank, hsync_raw, vblank, vsync_raw;
  logic [HC_W-1:0] char_cnt;
  logic [VC_W-1:0] line_cnt;

  crtc_shadow_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .load_i    (frame_end),
    .act_o     (cfg_act),
    .nxt_o     (cfg_nxt)
  );

  crtc_hgen #(.DOT_W(DOT_W), .BE_W(HBE_CMP_W), .SE_W(HSE_CMP_W)) u_hgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pix_en_i   (pix_en_i),
    .cur_i      (cfg_act),
    .nxt_i      (cfg_nxt),
    .char_o     (char_cnt),
    .line_end_o (line_end),
    .blank_o    (hblank),
    .sync_o     (hsync_raw)
  );

  crtc_vgen #(.BE_W(VBE_CMP_W), .SE_W(VSE_CMP_W)) u_vgen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_adv_i  (line_end),
    .cur_i       (cfg_act),
    .nxt_i       (cfg_nxt),
    .line_o      (line_cnt),
    .frame_end_o (frame_end),
    .blank_o     (vblank),
    .sync_o      (vsync_raw)
  );

  assign hsync_o    = (hsync_raw && !cfg_act.hdis) ^ cfg_act.hneg;
  assign vsync_o    = (vsync_raw && !cfg_act.vdis) ^ cfg_act.vneg;
  assign de_o       = (char_cnt <= cfg_act.hde) && (line_cnt <= cfg_act.vde) && !cfg_act.scr_off;
  assign blank_o    = hblank || vblank || cfg_act.scr_off;
  assign line_o     = line_cnt;
  assign vretrace_o = vsync_raw;
endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk
  import crtc_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            pix_en_i,
  input logic [VC_W-1:0] line_o,
  input logic            de_o,
  input logic            hsync_o,
  input logic            vsync_o,
  input logic            blank_o,
  input crtc_cfg_t       act_i
);
  AST_LINE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (line_o == $past(line_o)) || (line_o == $past(line_o) + VC_W'(1)) || (line_o == '0)); // R3

  AST_LINE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, line_o} <= ({1'b0, act_i.vtot} + (VC_W+1)'(1))); // R3

  AST_DE_IN_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (line_o <= act_i.vde)); // R4

  AST_HSYNC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i.hdis |-> (hsync_o == act_i.hneg)); // R10

  AST_VSYNC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i.vdis |-> (vsync_o == act_i.vneg)); // R10

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_i |=> $stable(line_o) && $stable(de_o) && $stable(hsync_o)
                  && $stable(vsync_o) && $stable(blank_o)); // R12
endmodule

bind crtc_timing_gen crtc_timing_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pix_en_i (pix_en_i),
  .line_o   (line_o),
  .de_o     (de_o),
  .hsync_o  (hsync_o),
  .vsync_o  (vsync_o),
  .blank_o  (blank_o),
  .act_i    (cfg_act)
);

// File: tb/crtc_timing_gen_bench.sv
module crtc_timing_gen_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pix_en = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic        hsync_o, vsync_o, de_o, blank_o, vretrace_o;
  logic [10:0] line_o;

  int n_chk = 0;
  int n_bad = 0;
  int pix_cnt = 0;
  int cyc = 0;
  bit timed_out = 1'b0;

  typedef struct {
    int htot, hde, hbs, hbe, hss, hse;
    int vtot, vde, vbs, vbe, vss, vse;
    int misc, ctl;
  } mode_t;

  typedef struct {
    int pix;
    int hs, vs, de, bl, vr, line;
    int tag;
  } item_t;

  item_t exp_q[$];

  crtc_timing_gen u_crtc_timing_gen (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .pix_en_i   (pix_en),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .hsync_o    (hsync_o),
    .vsync_o    (vsync_o),
    .de_o       (de_o),
    .blank_o    (blank_o),
    .line_o     (line_o),
    .vretrace_o (vretrace_o)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (rst_ni && pix_en) pix_cnt++;
  end

  task automatic chk(input string req, input int tag, input int pix, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (frame R%0d) pixel=%0d actual=%0d expected=%0d", req, tag, pix, act, exp);
    end
  endtask

  // driver: expected outputs for every pixel of one frame, from the requirements
  task automatic push_frame(input mode_t m, input int start, input int tag);
    int hc = m.htot + 5;
    int vl = m.vtot + 2;
    int hb_end = hc;
    int vb_end = vl;
    int hw = (m.hse - m.hss) & 31;
    int vw = (m.vse - m.vss) & 15;
    bit off  = m.ctl[5];
    bit hdis = m.ctl[7];
    bit vdis = m.ctl[6];
    bit hneg = m.misc[6];
    bit vneg = m.misc[7];
    if (hw == 0) hw = 32;   // R7
    if (vw == 0) vw = 16;   // R8
    for (int k = m.hbs + 2; k < hc; k++)
      if (hb_end == hc && (k % 64) == (m.hbe % 64)) hb_end = k;   // R5
    for (int k = m.vbs + 2; k < vl; k++)
      if (vb_end == vl && (k % 256) == (m.vbe % 256)) vb_end = k; // R6
    for (int y = 0; y < vl; y++) begin
      for (int x = 0; x < hc * 8; x++) begin
        item_t it;
        int c = x / 8;
        bit hs_raw = (c >= m.hss) && (c < m.hss + hw);
        bit vs_raw = (y >= m.vss) && (y < m.vss + vw);
        bit hb = (c > m.hbs) && (c < hb_end);
        bit vb = (y > m.vbs) && (y < vb_end);
        it.pix  = start + y * hc * 8 + x;
        it.hs   = int'((hs_raw && !hdis) ^ hneg);
        it.vs   = int'((vs_raw && !vdis) ^ vneg);
        it.de   = int'((c <= m.hde) && (y <= m.vde) && !off);
        it.bl   = int'(hb || vb || off);
        it.vr   = int'(vs_raw);
        it.line = y;
        it.tag  = tag;
        exp_q.push_back(it);
      end
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en   = 1'b1;
    wr_addr = 4'(a);
    wr_data = 12'(d);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // R11: address map of the write port
  task automatic wr_mode(input mode_t m);
    wr(0, m.htot);  wr(1, m.hde);  wr(2, m.hbs);  wr(3, m.hbe);
    wr(4, m.hss);   wr(5, m.hse);  wr(6, m.vtot); wr(7, m.vde);
    wr(8, m.vbs);   wr(9, m.vbe);  wr(10, m.vss); wr(11, m.vse);
    wr(12, m.misc); wr(13, m.ctl);
  endtask

  task automatic wait_pix(input int n);
    while (pix_cnt < n && !timed_out) @(negedge clk);
  endtask

  // monitor: pops one expected item per displayed pixel
  always @(negedge clk) begin
    if (rst_ni && exp_q.size() > 0 && exp_q[0].pix == pix_cnt) begin
      item_t it;
      it = exp_q.pop_front();
      chk("R3 line",        it.tag, it.pix, int'(line_o),     it.line);
      chk("R4 de",          it.tag, it.pix, int'(de_o),       it.de);
      chk("R5/R6 blank",    it.tag, it.pix, int'(blank_o),    it.bl);
      chk("R7 hsync",       it.tag, it.pix, int'(hsync_o),    it.hs);
      chk("R8 vsync",       it.tag, it.pix, int'(vsync_o),    it.vs);
      chk("R8 vretrace",    it.tag, it.pix, int'(vretrace_o), it.vr);
    end
  end

  always @(posedge clk) if (cyc > 100000) timed_out = 1'b1;

  initial begin
    mode_t m_def, m_a, m_b, m_c, m_d;
    logic [15:0] lfsr = 16'hace1;
    int f_a, f_b, f_c, f_d;
    m_def = '{htot:5, hde:5, hbs:5, hbe:9, hss:7, hse:8,
              vtot:6, vde:5, vbs:5, vbe:7, vss:6, vse:7, misc:0, ctl:0};
    // R2 R3: a plain mode, 16 chars by 12 lines
    m_a   = '{htot:11, hde:9, hbs:9, hbe:15, hss:11, hse:13,
              vtot:10, vde:7, vbs:7, vbe:11, vss:9, vse:10, misc:0, ctl:0};
    // R5 R6: blank ends carry bits above the compare; R7 R8: full-wrap widths; R9 both negative
    m_b   = '{htot:43, hde:7, hbs:7, hbe:111, hss:10, hse:42,
              vtot:22, vde:3, vbs:3, vbe:279, vss:4, vse:4, misc:8'hc0, ctl:0};
    // R10: hsync held, screen off; R9 hsync negative
    m_c   = m_b; m_c.misc = 8'h40; m_c.ctl = 8'ha0;
    // R10: vsync held; R12 under stalls
    m_d   = m_b; m_d.misc = 8'h80; m_d.ctl = 8'h40;

    f_a = 10 * 8 * 8;
    f_b = f_a + 16 * 8 * 12;
    f_c = f_b + 48 * 8 * 24;
    f_d = f_c + 48 * 8 * 24;
    push_frame(m_def, 0,   11); // R1 defaults, R11 writes during this frame have no effect
    push_frame(m_a,   f_a, 2);
    push_frame(m_b,   f_b, 9);
    push_frame(m_c,   f_c, 10);
    push_frame(m_d,   f_d, 12);

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 line",  1, 0, int'(line_o),     0);
    chk("R1 de",    1, 0, int'(de_o),       1);
    chk("R1 blank", 1, 0, int'(blank_o),    0);
    chk("R1 hsync", 1, 0, int'(hsync_o),    0);
    chk("R1 vsync", 1, 0, int'(vsync_o),    0);
    chk("R1 vretrace", 1, 0, int'(vretrace_o), 0);
    rst_ni = 1'b1;

    wait_pix(20);        wr_mode(m_a);
    wait_pix(f_a + 20);  wr_mode(m_b);
    wait_pix(f_b + 20);  wr_mode(m_c);
    wait_pix(f_c + 20);  wr_mode(m_d);
    wait_pix(f_d);
    // R12: irregular pixel enable through the last frame
    while (exp_q.size() > 0 && !timed_out) begin
      lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pix_en = (lfsr[1:0] != 2'b00);
      @(negedge clk);
    end
    pix_en = 1'b1;

    if (timed_out) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R12 actual=%0d expected=0 items left", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule